// File: doc/BRIEF.md
# Dual-Role A-Side Session Controller

This block runs a bus session for a dual-role port whose identification pin is held low. In that case the port is the A side: it is always the host and it supplies bus power. Software asks for a session with a one-cycle start strobe. The block then switches on the bus power drive and waits until the 2-bit power level input reports the top band. After that it watches for a peripheral to attach, records whether the peripheral is full speed or low speed, and holds bus reset on the attached device for a fixed number of clock cycles.

A session ends in one of three ways: software gives a stop strobe, babble is reported, or the power level falls below the session-valid band once it had been valid. A fall of the power level also locks out new sessions until the level has reached the session-end band, because a device that draws a large current would otherwise make the port drop out of host role again and again. Connect and babble events come out as one-cycle pulses, and each pulse also sets a pending bit that stays high until a read strobe clears it. The analog comparators and the line-state detection sit outside the block and reach it as plain inputs.

Top module: `otg_a_session`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every output is 0.
- R2: A `sess_start` strobe that arrives while no session is active, with `id_pin` = 0 and `relock` = 0, raises `vbus_drv` and `host_mode` on the next clock edge. A strobe that arrives with `id_pin` = 1 changes no output.
- R3: `vbus_lvl` is encoded as 0 = below session end, 1 = above session end, 2 = above session valid, 3 = above bus valid. Until `vbus_lvl` has read 3 during the session, `attach` is ignored: no `conn_irq`, no speed flag and no `bus_rst` follow from it.
- R4: An `attach` seen after the level has read 3 produces a single-cycle `conn_irq` on the next edge. On that same edge exactly one speed flag rises: `ls_dev` when `attach_ls` = 1, otherwise `fs_dev`.
- R5: `bus_rst` rises on the same edge as `conn_irq` and stays high for exactly RST_CYCLES cycles.
- R6: A `sess_stop` strobe during a session lowers `vbus_drv`, `host_mode`, `bus_rst`, `fs_dev` and `ls_dev` on the next edge.
- R7: `babble` high once the level has read 3 ends the session on the next edge and produces a single-cycle `babble_irq` on that edge.
- R8: `vbus_lvl` below 2 once the level has read 3 ends the session on the next edge and raises `relock` on that edge.
- R9: While `relock` = 1, `sess_start` is ignored. `relock` falls on the edge after a cycle in which `vbus_lvl` = 0.
- R10: `conn_pend` and `babble_pend` rise on the edge after their interrupt pulse and hold until an `irq_ack` strobe. If a pulse and `irq_ack` come in the same cycle, the bit stays set.
- R11: When `sess_stop` and `babble` come in the same cycle, the session ends without a `babble_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_pin | input | 1 | Identification pin, 0 selects the A side |
| sess_start | input | 1 | Software request to start a session (strobe) |
| sess_stop | input | 1 | Software request to end the session (strobe) |
| vbus_lvl | input | 2 | Bus power band from the comparators |
| attach | input | 1 | Peripheral attach seen on the line |
| attach_ls | input | 1 | Attached peripheral is low speed |
| babble | input | 1 | Babble reported by the receive path |
| irq_ack | input | 1 | Read strobe that clears the pending bits |
| vbus_drv | output | 1 | Bus power drive enable |
| host_mode | output | 1 | Port is in host role |
| bus_rst | output | 1 | Drive bus reset on the attached device |
| fs_dev | output | 1 | Full-speed peripheral attached |
| ls_dev | output | 1 | Low-speed peripheral attached |
| conn_irq | output | 1 | Connect pulse |
| babble_irq | output | 1 | Babble pulse |
| conn_pend | output | 1 | Pending connect event |
| babble_pend | output | 1 | Pending babble event |
| relock | output | 1 | New sessions blocked until the level reaches 0 |

## Verification
The hardest case to reach is the lockout after a power sag. The bench must first bring a session all the way past the valid level and through an attach, then lower the level only to the session-end band, and then give a start strobe while the level is still above zero. Only after that does it let the level reach zero and try again. A second awkward case is two ending causes in the same cycle. The bench drives the stop strobe and babble on one edge and expects no babble pulse. A cycle-by-cycle model in the bench checks every output on every clock through all of these runs.

// File: rtl/otg_a_pkg.sv
package otg_a_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RAMP   = 3'd1,
        PH_LISTEN = 3'd2,
        PH_BRST   = 3'd3,
        PH_LINKED = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        SPD_NONE = 2'd0,
        SPD_FULL = 2'd1,
        SPD_LOW  = 2'd2
    } speed_e;

    localparam logic [1:0] LVL_END   = 2'd0;
    localparam logic [1:0] LVL_SVLD  = 2'd2;
    localparam logic [1:0] LVL_BVLD  = 2'd3;

    localparam int EVT_CONN   = 0;
    localparam int EVT_BABBLE = 1;
    localparam int EVT_N      = 2;

    function automatic logic power_proven(phase_e ph);
        return (ph == PH_LISTEN) || (ph == PH_BRST) || (ph == PH_LINKED);
    endfunction

    function automatic logic below_valid(logic [1:0] lvl);
        return lvl < LVL_SVLD;
    endfunction

endpackage

// File: rtl/otg_a_timer.sv
module otg_a_timer #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/otg_a_sticky.sv
module otg_a_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         ack,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
            end else if (set[g]) begin
                pend[g] <= 1'b1;
            end else if (ack) begin
                pend[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/otg_a_ctrl.sv
module otg_a_ctrl
    import otg_a_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       id_pin,
    input  logic       sess_start,
    input  logic       sess_stop,
    input  logic [1:0] vbus_lvl,
    input  logic       attach,
    input  logic       attach_ls,
    input  logic       babble,
    output phase_e     phase,
    output speed_e     speed,
    output logic       conn_pulse,
    output logic       babble_pulse,
    output logic       lock
);
    phase_e phase_d;
    logic   proven, sag, bab_hit, ending, take_attach, tmr_done;

    always_comb begin
        proven      = power_proven(phase);
        sag         = proven && below_valid(vbus_lvl);
        bab_hit     = proven && babble;
        ending      = (phase != PH_IDLE) && (sess_stop || bab_hit || sag);
        take_attach = (phase == PH_LISTEN) && attach && !ending;
    end

    otg_a_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (take_attach),
        .run  (phase == PH_BRST),
        .done (tmr_done)
    );

    always_comb begin
        phase_d = phase;
        if (ending) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:   if (sess_start && !id_pin && !lock) phase_d = PH_RAMP;
                PH_RAMP:   if (vbus_lvl == LVL_BVLD) phase_d = PH_LISTEN;
                PH_LISTEN: if (attach) phase_d = PH_BRST;
                PH_BRST:   if (tmr_done) phase_d = PH_LINKED;
                PH_LINKED: phase_d = PH_LINKED;
                default:   phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            speed        <= SPD_NONE;
            conn_pulse   <= 1'b0;
            babble_pulse <= 1'b0;
            lock         <= 1'b0;
        end else begin
            phase        <= phase_d;
            conn_pulse   <= take_attach;
            babble_pulse <= bab_hit && !sess_stop;
            if (ending) begin
                speed <= SPD_NONE;
            end else if (take_attach) begin
                speed <= attach_ls ? SPD_LOW : SPD_FULL;
            end
            if (ending && sag) begin
                lock <= 1'b1;
            end else if (vbus_lvl == LVL_END) begin
                lock <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/otg_a_session.sv
module otg_a_session
    import otg_a_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       id_pin,
    input  logic       sess_start,
    input  logic       sess_stop,
    input  logic [1:0] vbus_lvl,
    input  logic       attach,
    input  logic       attach_ls,
    input  logic       babble,
    input  logic       irq_ack,
    output logic       vbus_drv,
    output logic       host_mode,
    output logic       bus_rst,
    output logic       fs_dev,
    output logic       ls_dev,
    output logic       conn_irq,
    output logic       babble_irq,
    output logic       conn_pend,
    output logic       babble_pend,
    output logic       relock
);
    phase_e           phase;
    speed_e           speed;
    logic [EVT_N-1:0] evt, pend;

    otg_a_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .id_pin       (id_pin),
        .sess_start   (sess_start),
        .sess_stop    (sess_stop),
        .vbus_lvl     (vbus_lvl),
        .attach       (attach),
        .attach_ls    (attach_ls),
        .babble       (babble),
        .phase        (phase),
        .speed        (speed),
        .conn_pulse   (evt[EVT_CONN]),
        .babble_pulse (evt[EVT_BABBLE]),
        .lock         (relock)
    );

    otg_a_sticky #(.N(EVT_N)) u_sticky (
        .clk  (clk),
        .rst  (rst),
        .set  (evt),
        .ack  (irq_ack),
        .pend (pend)
    );

    assign vbus_drv    = (phase != PH_IDLE);
    assign host_mode   = (phase != PH_IDLE);
    assign bus_rst     = (phase == PH_BRST);
    assign fs_dev      = (speed == SPD_FULL);
    assign ls_dev      = (speed == SPD_LOW);
    assign conn_irq    = evt[EVT_CONN];
    assign babble_irq  = evt[EVT_BABBLE];
    assign conn_pend   = pend[EVT_CONN];
    assign babble_pend = pend[EVT_BABBLE];
endmodule

// File: rtl/otg_a_session_chk.sv
module otg_a_session_chk (
    input logic       clk,
    input logic       rst,
    input logic       sess_start,
    input logic       sess_stop,
    input logic       babble,
    input logic       irq_ack,
    input logic       vbus_drv,
    input logic       bus_rst,
    input logic       fs_dev,
    input logic       ls_dev,
    input logic       conn_irq,
    input logic       babble_irq,
    input logic       conn_pend,
    input logic       relock
);
    // R4: speed flags never both high
    a_r4_one_speed: assert property (@(posedge clk) disable iff (rst)
        !(fs_dev && ls_dev));

    // R4: connect pulse lasts one cycle
    a_r4_conn_single: assert property (@(posedge clk) disable iff (rst)
        conn_irq |=> !conn_irq);

    // R5: bus reset only inside a powered session
    a_r5_rst_powered: assert property (@(posedge clk) disable iff (rst)
        bus_rst |-> vbus_drv);

    // R6: stop strobe drops power on the next edge
    a_r6_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (vbus_drv && sess_stop) |=> !vbus_drv);

    // R9: start strobe blocked while locked
    a_r9_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (relock && !vbus_drv && sess_start) |=> !vbus_drv);

    // R10: pending bit follows its pulse
    a_r10_pend_set: assert property (@(posedge clk) disable iff (rst)
        conn_irq |=> conn_pend);

    // R11: stop beats babble
    a_r11_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (sess_stop && babble) |=> !babble_irq);

    // R10: ack without a pulse clears
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !conn_irq) |=> !conn_pend);
endmodule

bind otg_a_session otg_a_session_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sess_start (sess_start),
    .sess_stop  (sess_stop),
    .babble     (babble),
    .irq_ack    (irq_ack),
    .vbus_drv   (vbus_drv),
    .bus_rst    (bus_rst),
    .fs_dev     (fs_dev),
    .ls_dev     (ls_dev),
    .conn_irq   (conn_irq),
    .babble_irq (babble_irq),
    .conn_pend  (conn_pend),
    .relock     (relock)
);

// File: tb/test_otg_a_session.sv
`timescale 1ns/1ps
module test_otg_a_session;
    localparam int RSTC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic id_pin = 1'b0, sess_start = 1'b0, sess_stop = 1'b0;
    logic [1:0] vbus_lvl = 2'd0;
    logic attach = 1'b0, attach_ls = 1'b0, babble = 1'b0, irq_ack = 1'b0;
    logic vbus_drv, host_mode, bus_rst, fs_dev, ls_dev;
    logic conn_irq, babble_irq, conn_pend, babble_pend, relock;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    otg_a_session #(.RST_CYCLES(RSTC)) i_otg_a_session (
        .clk(clk), .rst(rst), .id_pin(id_pin), .sess_start(sess_start),
        .sess_stop(sess_stop), .vbus_lvl(vbus_lvl), .attach(attach),
        .attach_ls(attach_ls), .babble(babble), .irq_ack(irq_ack),
        .vbus_drv(vbus_drv), .host_mode(host_mode), .bus_rst(bus_rst),
        .fs_dev(fs_dev), .ls_dev(ls_dev), .conn_irq(conn_irq),
        .babble_irq(babble_irq), .conn_pend(conn_pend),
        .babble_pend(babble_pend), .relock(relock)
    );

    // Reference model: 0 idle, 1 ramp, 2 listen, 3 reset, 4 linked
    int m_ph = 0, m_left = 0, m_spd = 0;
    bit m_lock = 0, m_ci = 0, m_bi = 0, m_cp = 0, m_bp = 0;
    bit pv, sg, bb, en;

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_left <= 0; m_spd <= 0;
            m_lock <= 0; m_ci <= 0; m_bi <= 0; m_cp <= 0; m_bp <= 0;
        end else begin
            pv = (m_ph >= 2);
            sg = pv && (vbus_lvl < 2);
            bb = pv && babble;
            en = (m_ph != 0) && (sess_stop || bb || sg);
            m_ci <= (m_ph == 2) && attach && !en;
            m_bi <= bb && !sess_stop;
            m_cp <= m_ci ? 1'b1 : (irq_ack ? 1'b0 : m_cp);
            m_bp <= m_bi ? 1'b1 : (irq_ack ? 1'b0 : m_bp);
            if (en && sg) m_lock <= 1'b1;
            else if (vbus_lvl == 0) m_lock <= 1'b0;
            if (en) begin
                m_ph <= 0; m_spd <= 0;
            end else if (m_ph == 0) begin
                if (sess_start && !id_pin && !m_lock) m_ph <= 1;
            end else if (m_ph == 1) begin
                if (vbus_lvl == 3) m_ph <= 2;
            end else if (m_ph == 2) begin
                if (attach) begin
                    m_ph <= 3; m_left <= RSTC; m_spd <= attach_ls ? 2 : 1;
                end
            end else if (m_ph == 3) begin
                if (m_left <= 1) m_ph <= 4;
                else m_left <= m_left - 1;
            end
        end
    end

    task automatic cmp(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        cmp("R2", "vbus_drv", vbus_drv, m_ph != 0);
        cmp("R2", "host_mode", host_mode, m_ph != 0);
        cmp("R5", "bus_rst", bus_rst, m_ph == 3);
        cmp("R4", "fs_dev", fs_dev, m_spd == 1);
        cmp("R4", "ls_dev", ls_dev, m_spd == 2);
        cmp("R4", "conn_irq", conn_irq, m_ci);
        cmp("R7", "babble_irq", babble_irq, m_bi);
        cmp("R10", "conn_pend", conn_pend, m_cp);
        cmp("R10", "babble_pend", babble_pend, m_bp);
        cmp("R8", "relock", relock, m_lock);
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic pulse_start();
        sess_start = 1; tick(); sess_start = 0;
    endtask

    task automatic reach_listen();
        pulse_start(); vbus_lvl = 3; tick(); tick();
    endtask

    task automatic do_attach(logic low);
        attach = 1; attach_ls = low; tick(); attach = 0; attach_ls = 0;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) tick();
        // R1 reset state
        cmp("R1", "vbus_drv in reset", vbus_drv, 1'b0);
        cmp("R1", "conn_pend in reset", conn_pend, 1'b0);
        rst = 0;
        tick();
        cmp("R1", "vbus_drv after reset", vbus_drv, 1'b0);
        cmp("R1", "relock after reset", relock, 1'b0);

        // R2: B side pin ignores start
        id_pin = 1; pulse_start(); tick();
        cmp("R2", "no start with id high", vbus_drv, 1'b0);
        id_pin = 0;

        // R3: attach ignored before level 3
        pulse_start();
        cmp("R2", "start raises drive", vbus_drv, 1'b1);
        vbus_lvl = 2; do_attach(1'b0); tick();
        cmp("R3", "attach ignored during ramp", conn_irq | fs_dev | bus_rst, 1'b0);
        vbus_lvl = 3; tick(); tick();
        do_attach(1'b0);
        cmp("R4", "conn pulse", conn_irq, 1'b1);
        cmp("R4", "full speed flag", fs_dev, 1'b1);
        n = 0;
        while (bus_rst && n < 50) begin n++; tick(); end
        cmp("R5", "reset length matches", n == RSTC, 1'b1);
        tick();
        // R6: stop strobe
        sess_stop = 1; tick(); sess_stop = 0;
        cmp("R6", "stop drops drive", vbus_drv, 1'b0);
        cmp("R6", "stop clears speed", fs_dev, 1'b0);
        irq_ack = 1; tick(); irq_ack = 0;
        cmp("R10", "ack clears conn_pend", conn_pend, 1'b0);

        // R7: babble, low speed
        reach_listen(); do_attach(1'b1);
        cmp("R4", "low speed flag", ls_dev, 1'b1);
        repeat (RSTC + 2) tick();
        babble = 1; tick(); babble = 0;
        cmp("R7", "babble pulse", babble_irq, 1'b1);
        cmp("R7", "babble ends session", vbus_drv, 1'b0);
        tick();
        irq_ack = 1; tick(); irq_ack = 0;
        cmp("R10", "ack clears babble_pend", babble_pend, 1'b0);

        // R11: stop and babble together, during bus reset
        reach_listen(); do_attach(1'b0);
        sess_stop = 1; babble = 1; tick(); sess_stop = 0; babble = 0;
        cmp("R11", "no babble pulse", babble_irq, 1'b0);
        cmp("R11", "session ended", vbus_drv, 1'b0);

        // R10: ack together with connect pulse keeps pending set
        irq_ack = 1; tick(); irq_ack = 0;
        reach_listen(); attach = 1; tick(); attach = 0;
        irq_ack = 1; tick(); irq_ack = 0;
        cmp("R10", "set wins over ack", conn_pend, 1'b1);

        // R8: sag during linked
        repeat (RSTC + 2) tick();
        vbus_lvl = 1; tick();
        cmp("R8", "sag ends session", vbus_drv, 1'b0);
        cmp("R8", "sag sets relock", relock, 1'b1);
        // R9: start blocked while level above zero
        pulse_start(); tick();
        cmp("R9", "start blocked", vbus_drv, 1'b0);
        vbus_lvl = 0; tick();
        cmp("R9", "relock clears at level 0", relock, 1'b0);
        pulse_start();
        cmp("R9", "start accepted after clear", vbus_drv, 1'b1);
        vbus_lvl = 3; repeat (4) tick();
        sess_stop = 1; tick(); sess_stop = 0;
        repeat (3) tick();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule